// File: doc/BRIEF.md
# Serial Port Bus Front End with Transmit and Receive Queues

This block sits between an APB bus and the bit-level machinery of a serial port. Software writes bytes to a data register, and they collect in a transmit queue. A transmit shifter takes them from that queue through a pop port. Bytes from a receiver enter a receive queue through a push port, which also carries framing-error, parity-error and break indications. Software takes them back out by reading the same data register. Each queue is one byte wide and 32 entries deep.

A status word reports the following:
- the live occupancy of both queues;
- full and half-level indications for each queue;
- whether the transmit queue and the transmit shift register are empty;
- whether received data is waiting;
- four sticky line-error flags.

Software clears an error flag by writing 0 into its bit position. Baud timing, bit framing, control settings and interrupts belong to neighbouring blocks.

Top module: `ser_apb_port`

## Requirements
- R1: After a synchronous reset, both queues are empty and all error flags are clear. With `tx_shift_empty` high, the status word then reads 0x0000_0086: bit 7, bit 2 and bit 1 are set, because an empty transmit queue is below half.
- R2: An APB write to offset 0x0 appends `pwdata[7:0]` to the transmit queue. A write while the queue holds 32 bytes is dropped. `tx_avail` is high while the queue is non-empty, and `tx_byte` shows the oldest byte. A cycle with `tx_pop` high removes that byte.
- R3: An APB read of offset 0x0 returns the oldest received byte in bits 7:0, with bits 31:8 zero, and removes that byte. A read while the receive queue is empty returns 0 and changes nothing.
- R4: Status (offset 0x4) bits 31:26 hold the receive queue count and bits 25:20 hold the transmit queue count. Bits 19:11 read as zero.
- R5: Status bit 10 is set when the receive queue holds 32 bytes. Bit 9 is set when the transmit queue holds 32 bytes.
- R6: Status bit 8 is set when the receive queue holds 16 or more bytes. Bit 7 is set when the transmit queue holds fewer than 16 bytes.
- R7: Status bit 2 is set when the transmit queue is empty. Bit 1 follows `tx_shift_empty`. Bit 0 is set when the receive queue is non-empty.
- R8: A receive push with `rx_ferr` high sets status bit 6. A push with `rx_perr` high sets bit 5, and a push with `rx_brk` high sets bit 3. Each flag stays set until software clears it.
- R9: A receive push while the receive queue holds 32 bytes sets status bit 4. The byte is discarded, and the queue count and contents stay unchanged.
- R10: An APB write to the status register clears each of bits 6:3 whose position holds 0 in `pwdata`, and leaves it unchanged where `pwdata` holds 1. A line event in the same cycle wins over the clear. All other status bits ignore the write.
- R11: A push and a pop on the same queue in the same cycle, with the queue neither empty nor full, leave its count unchanged.
- R12: Every APB transfer completes without wait states: `pready` is always 1 and `pslverr` is always 0. Reads of offsets other than 0x0 and 0x4 return 0, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write when high |
| paddr | input | ADDR_W | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| pready | output | 1 | APB ready, always high |
| pslverr | output | 1 | APB error, always low |
| rx_push | input | 1 | Receiver delivers a byte |
| rx_byte | input | 8 | Received byte |
| rx_ferr | input | 1 | Framing error with this push |
| rx_perr | input | 1 | Parity error with this push |
| rx_brk | input | 1 | Break indication with this push |
| tx_pop | input | 1 | Shifter takes the head byte |
| tx_byte | output | 8 | Oldest byte in the transmit queue |
| tx_avail | output | 1 | Transmit queue non-empty |
| tx_shift_empty | input | 1 | Transmit shift register is empty |

## Verification
A pointer or count that drifts inside either queue shows at once in the count fields of the next status read. It also shows a cycle later as a wrong byte on `tx_byte` or on a data-register read. The bench therefore reads status after every single push and pop across the full 0 to 32 occupancy range. This catches a wrong byte order, an off-by-one at a half or full boundary, or a lost sticky flag within one transfer of the fault. The overrun and same-cycle push/pop cases are exercised because a wrong count there only shows when the queue is later drained.

// File: rtl/ser_pkg.sv
package ser_pkg;
    localparam int BYTE_W     = 8;
    localparam int WORD_W     = 32;
    localparam int CNT_FIELD  = 6;
    localparam int WIDX_DATA  = 0;
    localparam int WIDX_STAT  = 1;

    typedef struct packed {
        logic frame;
        logic parity;
        logic overrun;
        logic brk;
    } line_flags_t;

    typedef struct packed {
        logic [CNT_FIELD-1:0] rx_cnt;
        logic [CNT_FIELD-1:0] tx_cnt;
        logic [8:0]           rsvd;
        logic                 rx_full;
        logic                 tx_full;
        logic                 rx_half;
        logic                 tx_below_half;
        line_flags_t          flags;
        logic                 tx_empty;
        logic                 shift_empty;
        logic                 rx_ready;
    } status_t;

    function automatic logic [WORD_W-1:0] byte_to_word(input logic [BYTE_W-1:0] b);
        return {{(WORD_W-BYTE_W){1'b0}}, b};
    endfunction
endpackage

// File: rtl/ser_fifo.sv
module ser_fifo #(
    parameter int DEPTH = 32,
    parameter int W     = 8,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic [W-1:0]     din,
    input  logic             pop,
    output logic [W-1:0]     dout,
    output logic [CNT_W-1:0] count,
    output logic             full,
    output logic             empty
);
    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic             do_push, do_pop;

    assign full    = (count == CNT_W'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rd_ptr];

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= bump(wr_ptr);
            if (do_pop)  rd_ptr <= bump(rd_ptr);
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/ser_flags.sv
module ser_flags
    import ser_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  line_flags_t set_ev,
    input  logic        sw_wr,
    input  line_flags_t sw_keep,
    output line_flags_t flags
);
    line_flags_t kept;

    always_comb begin
        kept = sw_wr ? (flags & sw_keep) : flags;
    end

    always_ff @(posedge clk) begin
        if (rst) flags <= '0;
        else     flags <= kept | set_ev;
    end
endmodule

// File: rtl/ser_apb_port.sv
module ser_apb_port
    import ser_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DEPTH  = 32,
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int HALF  = DEPTH / 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [31:0]       pwdata,
    output logic [31:0]       prdata,
    output logic              pready,
    output logic              pslverr,
    input  logic              rx_push,
    input  logic [7:0]        rx_byte,
    input  logic              rx_ferr,
    input  logic              rx_perr,
    input  logic              rx_brk,
    input  logic              tx_pop,
    output logic [7:0]        tx_byte,
    output logic              tx_avail,
    input  logic              tx_shift_empty
);
    logic [ADDR_W-3:0] widx;
    logic              access, rd_data, wr_data, wr_stat;
    logic [CNT_W-1:0]  rx_cnt, tx_cnt;
    logic              rx_full, rx_empty, tx_full, tx_empty;
    logic [7:0]        rx_head;
    line_flags_t       ev, keep, flags;
    status_t           stat;

    assign widx    = paddr[ADDR_W-1:2];
    assign access  = psel && penable;
    assign rd_data = access && !pwrite && (widx == (ADDR_W-2)'(WIDX_DATA));
    assign wr_data = access &&  pwrite && (widx == (ADDR_W-2)'(WIDX_DATA));
    assign wr_stat = access &&  pwrite && (widx == (ADDR_W-2)'(WIDX_STAT));
    assign pready  = 1'b1;
    assign pslverr = 1'b0;

    ser_fifo #(.DEPTH(DEPTH), .W(BYTE_W)) u_rxq (
        .clk(clk), .rst(rst),
        .push(rx_push), .din(rx_byte),
        .pop(rd_data), .dout(rx_head),
        .count(rx_cnt), .full(rx_full), .empty(rx_empty)
    );

    ser_fifo #(.DEPTH(DEPTH), .W(BYTE_W)) u_txq (
        .clk(clk), .rst(rst),
        .push(wr_data), .din(pwdata[7:0]),
        .pop(tx_pop), .dout(tx_byte),
        .count(tx_cnt), .full(tx_full), .empty(tx_empty)
    );

    assign tx_avail = !tx_empty;

    always_comb begin
        ev.frame   = rx_push && rx_ferr;
        ev.parity  = rx_push && rx_perr;
        ev.brk     = rx_push && rx_brk;
        ev.overrun = rx_push && rx_full;
        keep.frame   = pwdata[6];
        keep.parity  = pwdata[5];
        keep.overrun = pwdata[4];
        keep.brk     = pwdata[3];
    end

    ser_flags u_flags (
        .clk(clk), .rst(rst),
        .set_ev(ev), .sw_wr(wr_stat), .sw_keep(keep),
        .flags(flags)
    );

    always_comb begin
        stat               = '0;
        stat.rx_cnt        = CNT_FIELD'(rx_cnt);
        stat.tx_cnt        = CNT_FIELD'(tx_cnt);
        stat.rx_full       = rx_full;
        stat.tx_full       = tx_full;
        stat.rx_half       = (rx_cnt >= CNT_W'(HALF));
        stat.tx_below_half = (tx_cnt <  CNT_W'(HALF));
        stat.flags         = flags;
        stat.tx_empty      = tx_empty;
        stat.shift_empty   = tx_shift_empty;
        stat.rx_ready      = !rx_empty;
    end

    always_comb begin
        prdata = '0;
        if (psel && !pwrite) begin
            if (widx == (ADDR_W-2)'(WIDX_DATA))
                prdata = rx_empty ? '0 : byte_to_word(rx_head);
            else if (widx == (ADDR_W-2)'(WIDX_STAT))
                prdata = stat;
        end
    end
endmodule

// File: rtl/ser_apb_port_chk.sv
module ser_apb_port_chk
    import ser_pkg::*;
#(
    parameter int DEPTH = 32,
    parameter int CNT_W = 6
) (
    input logic             clk,
    input logic             rst,
    input logic             pready,
    input logic             pslverr,
    input logic             rx_push,
    input logic             rx_full,
    input logic             rx_pop,
    input logic [CNT_W-1:0] rx_cnt,
    input logic [CNT_W-1:0] tx_cnt,
    input logic             wr_stat,
    input line_flags_t      flags
);
    AST_NO_WAIT: assert property (@(posedge clk) disable iff (rst)
        pready && !pslverr); // R12

    AST_RX_BOUND: assert property (@(posedge clk) disable iff (rst)
        rx_cnt <= CNT_W'(DEPTH)); // R4

    AST_TX_BOUND: assert property (@(posedge clk) disable iff (rst)
        tx_cnt <= CNT_W'(DEPTH)); // R2

    AST_OVR_SET: assert property (@(posedge clk) disable iff (rst)
        rx_push && rx_full |=> flags.overrun); // R9

    AST_OVR_KEEP: assert property (@(posedge clk) disable iff (rst)
        rx_push && rx_full && !rx_pop |=> rx_cnt == CNT_W'(DEPTH)); // R9

    AST_STICKY: assert property (@(posedge clk) disable iff (rst)
        !wr_stat |=> ((flags & $past(flags)) == $past(flags))); // R8

    AST_PUSH_POP: assert property (@(posedge clk) disable iff (rst)
        rx_push && rx_pop && !rx_full && rx_cnt != '0 |=> $stable(rx_cnt)); // R11
endmodule

bind ser_apb_port ser_apb_port_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst(rst), .pready(pready), .pslverr(pslverr),
    .rx_push(rx_push), .rx_full(rx_full), .rx_pop(rd_data),
    .rx_cnt(rx_cnt), .tx_cnt(tx_cnt), .wr_stat(wr_stat), .flags(flags)
);

// File: tb/sim_ser_apb_port.sv
`timescale 1ns/1ps
module sim_ser_apb_port;
    localparam int D = 32;

    logic        clk = 0;
    logic        rst = 1;
    logic        psel = 0, penable = 0, pwrite = 0;
    logic [7:0]  paddr = 0;
    logic [31:0] pwdata = 0;
    logic [31:0] prdata;
    logic        pready, pslverr;
    logic        rx_push = 0, rx_ferr = 0, rx_perr = 0, rx_brk = 0;
    logic [7:0]  rx_byte = 0;
    logic        tx_pop = 0;
    logic [7:0]  tx_byte;
    logic        tx_avail;
    logic        tx_shift_empty = 1;

    int n_cmp = 0, n_bad = 0;
    bit done = 0;

    always #5 clk = ~clk;

    ser_apb_port u0 (
        .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready),
        .pslverr(pslverr), .rx_push(rx_push), .rx_byte(rx_byte),
        .rx_ferr(rx_ferr), .rx_perr(rx_perr), .rx_brk(rx_brk),
        .tx_pop(tx_pop), .tx_byte(tx_byte), .tx_avail(tx_avail),
        .tx_shift_empty(tx_shift_empty)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    // flags4: {frame, parity, overrun, brk}
    function automatic logic [31:0] exp_stat(int rxc, int txc, logic [3:0] fl, logic ts);
        logic [31:0] s;
        s = (32'(rxc) << 26) | (32'(txc) << 20);
        if (rxc == D)     s |= 32'h400;
        if (txc == D)     s |= 32'h200;
        if (rxc >= D/2)   s |= 32'h100;
        if (txc <  D/2)   s |= 32'h080;
        s |= 32'(fl) << 3;
        if (txc == 0)     s |= 32'h004;
        if (ts)           s |= 32'h002;
        if (rxc > 0)      s |= 32'h001;
        return s;
    endfunction

    task automatic apb_wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        psel = 1; penable = 0; pwrite = 1; paddr = a; pwdata = d;
        @(negedge clk);
        penable = 1;
        @(negedge clk);
        psel = 0; penable = 0; pwrite = 0;
    endtask

    task automatic apb_rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        psel = 1; penable = 0; pwrite = 0; paddr = a;
        @(negedge clk);
        penable = 1;
        #1;
        d = prdata;
        check("R12 pready/pslverr", {30'd0, pready, pslverr}, 32'h2);
        @(negedge clk);
        psel = 0; penable = 0;
    endtask

    task automatic line_push(input logic [7:0] b, input logic fe, input logic pe, input logic bk);
        @(negedge clk);
        rx_push = 1; rx_byte = b; rx_ferr = fe; rx_perr = pe; rx_brk = bk;
        @(negedge clk);
        rx_push = 0; rx_ferr = 0; rx_perr = 0; rx_brk = 0;
    endtask

    task automatic stat_chk(input string req, input logic [31:0] exp);
        logic [31:0] s;
        apb_rd(8'h04, s);
        check(req, s, exp);
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual 0x00000001 expected 0x00000000");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        logic [3:0]  fl;
        int          rxc, txc;
        repeat (3) @(negedge clk);
        rst = 0;

        // R1: reset state
        stat_chk("R1 reset status", 32'h0000_0086);
        check("R2 tx_avail after reset", {31'd0, tx_avail}, 32'd0);

        // R4 R5 R6 R7: receive sweep over every occupancy level
        fl = 0;
        for (int i = 0; i < D; i++) begin
            line_push(8'((i * 7 + 3) & 8'hff), 0, 0, 0);
            stat_chk("R4 R5 R6 R7 rx fill", exp_stat(i + 1, 0, fl, 1'b1));
        end

        // R9: overrun push discards byte
        line_push(8'hEE, 0, 0, 0);
        fl = 4'b0010;
        stat_chk("R9 overrun status", exp_stat(D, 0, fl, 1'b1));

        // R3: drain in order, counts follow
        for (int i = 0; i < D; i++) begin
            apb_rd(8'h00, d);
            check("R3 rx byte order", d, 32'((i * 7 + 3) & 8'hff));
            stat_chk("R4 R6 R8 rx drain", exp_stat(D - 1 - i, 0, fl, 1'b1));
        end
        apb_rd(8'h00, d);
        check("R3 empty read", d, 32'd0);
        stat_chk("R3 empty read no change", exp_stat(0, 0, fl, 1'b1));

        // R10: clear overrun via write of 0 at bit 4
        apb_wr(8'h04, 32'hFFFF_FFEF);
        fl = 0;
        stat_chk("R10 clear overrun", exp_stat(0, 0, fl, 1'b1));

        // R8: line events
        line_push(8'h11, 1, 0, 0);
        line_push(8'h22, 0, 1, 0);
        line_push(8'h33, 0, 0, 1);
        fl = 4'b1101;
        stat_chk("R8 sticky events", exp_stat(3, 0, fl, 1'b1));
        apb_wr(8'h04, 32'hFFFF_FFFF);
        stat_chk("R10 write ones keeps", exp_stat(3, 0, fl, 1'b1));
        apb_wr(8'h04, 32'hFFFF_FFBF);
        fl = 4'b0101;
        stat_chk("R10 clear frame only", exp_stat(3, 0, fl, 1'b1));
        apb_wr(8'h04, 32'h0000_0000);
        fl = 0;
        stat_chk("R10 clear all, RO bits kept", exp_stat(3, 0, fl, 1'b1));

        // R11: receive push and data read in the same cycle
        @(negedge clk);
        psel = 1; pwrite = 0; paddr = 8'h00; penable = 0;
        @(negedge clk);
        penable = 1; rx_push = 1; rx_byte = 8'h44;
        #1;
        check("R11 rx head during simultaneous", prdata, 32'h11);
        @(negedge clk);
        psel = 0; penable = 0; rx_push = 0;
        stat_chk("R11 rx count unchanged", exp_stat(3, 0, fl, 1'b1));
        for (int i = 0; i < 3; i++) begin
            apb_rd(8'h00, d);
            check("R11 rx order after simultaneous", d, (i == 0) ? 32'h22 : (i == 1) ? 32'h33 : 32'h44);
        end

        // R2 R5 R6: transmit sweep, 33rd write dropped
        rxc = 0;
        for (int i = 0; i <= D; i++) begin
            apb_wr(8'h00, 32'hABCD_0000 | 32'((i * 13 + 5) & 8'hff));
            txc = (i + 1 > D) ? D : i + 1;
            stat_chk("R2 R5 R6 tx fill", exp_stat(rxc, txc, fl, 1'b1));
        end
        check("R2 tx_avail full", {31'd0, tx_avail}, 32'd1);

        // R7: shift-empty input
        tx_shift_empty = 0;
        stat_chk("R7 shift busy", exp_stat(0, D, fl, 1'b0));
        tx_shift_empty = 1;

        // R2: pop order
        for (int i = 0; i < D; i++) begin
            @(negedge clk);
            check("R2 tx head byte", {24'd0, tx_byte}, 32'((i * 13 + 5) & 8'hff));
            tx_pop = 1;
            @(negedge clk);
            tx_pop = 0;
            stat_chk("R2 R6 R7 tx drain", exp_stat(0, D - 1 - i, fl, 1'b1));
        end
        check("R2 tx_avail empty", {31'd0, tx_avail}, 32'd0);

        // R11: transmit write and pop in the same cycle
        apb_wr(8'h00, 32'h0000_0061);
        apb_wr(8'h00, 32'h0000_0062);
        @(negedge clk);
        psel = 1; pwrite = 1; paddr = 8'h00; pwdata = 32'h63; penable = 0;
        @(negedge clk);
        penable = 1; tx_pop = 1;
        @(negedge clk);
        psel = 0; penable = 0; pwrite = 0; tx_pop = 0;
        stat_chk("R11 tx count unchanged", exp_stat(0, 2, fl, 1'b1));
        check("R11 tx head after simultaneous", {24'd0, tx_byte}, 32'h62);

        // R12: unmapped offsets
        apb_rd(8'h08, d);
        check("R12 unmapped read", d, 32'd0);
        apb_wr(8'h0C, 32'h0000_0000);
        apb_wr(8'h10, 32'hFFFF_FFFF);
        stat_chk("R12 unmapped write ignored", exp_stat(0, 2, fl, 1'b1));

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule